// File: doc/BRIEF.md
# SPI FIFO Threshold and Interrupt Controller

This block holds the transmit and receive byte FIFOs of an SPI controller and turns their fill levels into interrupt and DMA-request flags. Software writes a FIFO control word that sets a separate trigger level for each direction, enables a DMA request per direction, and can flush either FIFO. The serial shifter pops transmit bytes and pushes received bytes. Software pushes transmit bytes and pops received bytes. Both sides see live occupancy counts.

Four status conditions are recorded in sticky bits: receive ready, transmit empty request, receive overflow and transfer complete. A status bit is cleared by writing one to it. An enable mask with the same bit layout selects which sticky bits drive the single interrupt line. The DMA request outputs follow the same level comparisons, gated only by their own enables. The bus decoder that produces the write strobes and the serial shifter are outside this block.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: A control write stores the receive trigger level from bits 7:0, the receive DMA enable from bit 8, the transmit trigger level from bits 23:16 and the transmit DMA enable from bit 24. `ctl_rdata` returns these fields in the same positions, and every other bit, including 15 and 31, reads 0.
- R2: A control write with bit 15 set empties the receive FIFO, and one with bit 31 set empties the transmit FIFO. Both can act in the same write, and the counts read 0 right after that write's clock edge.
- R3: `occ_rdata` carries the receive count in bits 7:0 and the transmit count in bits 23:16, with all other bits 0. Each FIFO returns bytes in the order they were pushed, and the head byte is visible before it is popped.
- R4: Status bit 0 (receive ready) becomes set one cycle after the receive count is greater than or equal to the receive trigger level.
- R5: Status bit 4 (transmit empty request) becomes set one cycle after the transmit count is less than or equal to the transmit trigger level.
- R6: A receive push while the receive FIFO is full, with no pop in the same cycle, drops the byte. The count stays at the depth, the stored bytes are unchanged, and status bit 8 (receive overflow) is set on the next cycle.
- R7: A one-cycle `xfer_done` pulse sets status bit 12 on the next cycle, and the bit stays set until it is cleared.
- R8: A status write clears each status bit whose write-data bit is 1 and leaves bits written 0 untouched. An all-ones write clears every bit. A level condition (bit 0 or 4) that still holds sets its bit again one cycle after the clear.
- R9: The enable register holds bits 0, 4, 8 and 12 and reads 0 elsewhere. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: `rx_dma_req` is high when the receive DMA enable is set and the receive count is at or above the receive level. `tx_dma_req` is high when the transmit DMA enable is set and the transmit count is at or below the transmit level. Neither depends on the interrupt enables.
- R11: A pop from an empty FIFO leaves its count at 0. A transmit push into a full transmit FIFO is dropped and the count stays at the depth.
- R12: While reset is held, the control, enable, status and occupancy reads are 0, and `irq`, `rx_dma_req` and `tx_dma_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_we | input | 1 | FIFO control write strobe |
| ctl_wdata | input | 32 | FIFO control write data |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 32 | Interrupt enable write data |
| sts_w1c | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Status clear mask |
| tx_push | input | 1 | Software pushes a transmit byte |
| tx_push_data | input | 8 | Transmit byte to push |
| tx_pop | input | 1 | Shifter takes the transmit head byte |
| tx_pop_data | output | 8 | Transmit head byte |
| tx_empty | output | 1 | Transmit FIFO is empty |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Software takes the receive head byte |
| rx_pop_data | output | 8 | Receive head byte |
| rx_empty | output | 1 | Receive FIFO is empty |
| xfer_done | input | 1 | Transfer-complete event pulse |
| ctl_rdata | output | 32 | FIFO control readback |
| ien_rdata | output | 32 | Interrupt enable readback |
| sts_rdata | output | 32 | Sticky status readback |
| occ_rdata | output | 32 | FIFO occupancy counts |
| irq | output | 1 | Combined interrupt line |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with a FIFO depth of 16 instead of the default 128. This lets a short run fill both FIFOs, overflow the receive side and wrap the pointers many times. With that depth, random trigger levels from 0 to 16 cover both ends of each comparison: a level of 0 keeps receive ready asserted all the time, and a level equal to the depth makes transmit empty request true at any occupancy. The random phase mixes simultaneous push and pop on both FIFOs, including push-while-full and pop-while-empty. Before each status check it clears the level bits and then waits one cycle, so the check sees the re-set behaviour directly.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LVL_W  = 8;

  // FIFO control word layout
  localparam int unsigned CTL_RX_LVL_LSB   = 0;
  localparam int unsigned CTL_RX_DMA_BIT   = 8;
  localparam int unsigned CTL_RX_FLUSH_BIT = 15;
  localparam int unsigned CTL_TX_LVL_LSB   = 16;
  localparam int unsigned CTL_TX_DMA_BIT   = 24;
  localparam int unsigned CTL_TX_FLUSH_BIT = 31;

  // Occupancy word layout
  localparam int unsigned OCC_RX_LSB = 0;
  localparam int unsigned OCC_TX_LSB = 16;

  // Status sources, index order; bit position is index * SRC_STRIDE
  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned SRC_STRIDE = 4;
  localparam int unsigned SRC_RX_RDY = 0;
  localparam int unsigned SRC_TX_ERQ = 1;
  localparam int unsigned SRC_RX_OVF = 2;
  localparam int unsigned SRC_DONE   = 3;

  typedef struct packed {
    logic [LVL_W-1:0] tx_lvl;
    logic             tx_dma_en;
    logic [LVL_W-1:0] rx_lvl;
    logic             rx_dma_en;
  } fifo_cfg_t;

  function automatic int unsigned src_pos(input int unsigned idx);
    return idx * SRC_STRIDE;
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          push,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  output logic [DATA_W-1:0]             pop_data,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          full,
  output logic                          empty,
  output logic                          overflow
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_FULL);
  assign pop_ok   = !flush && pop && !empty;
  assign push_ok  = !flush && push && (!full || pop_ok);
  assign overflow = !flush && push && full && !pop_ok;
  assign pop_data = mem[rd_q];
  assign count    = cnt_q;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = ptr_next(wr_q);
      if (pop_ok)  rd_d = ptr_next(rd_q);
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_q] <= push_data;
    end
  end

endmodule

// File: rtl/spi_fifo_cfg_reg.sv
module spi_fifo_cfg_reg
  import spi_fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output fifo_cfg_t        cfg,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic [REG_W-1:0] rdata
);

  fifo_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.rx_lvl    = wdata[CTL_RX_LVL_LSB +: LVL_W];
      cfg_d.rx_dma_en = wdata[CTL_RX_DMA_BIT];
      cfg_d.tx_lvl    = wdata[CTL_TX_LVL_LSB +: LVL_W];
      cfg_d.tx_dma_en = wdata[CTL_TX_DMA_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // flush strobes act in the cycle of the write itself
  assign rx_flush = we && wdata[CTL_RX_FLUSH_BIT];
  assign tx_flush = we && wdata[CTL_TX_FLUSH_BIT];
  assign cfg      = cfg_q;

  always_comb begin
    rdata = '0;
    rdata[CTL_RX_LVL_LSB +: LVL_W] = cfg_q.rx_lvl;
    rdata[CTL_RX_DMA_BIT]          = cfg_q.rx_dma_en;
    rdata[CTL_TX_LVL_LSB +: LVL_W] = cfg_q.tx_lvl;
    rdata[CTL_TX_DMA_BIT]          = cfg_q.tx_dma_en;
  end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_fifo_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               en_we,
  input  logic [REG_W-1:0]   en_wdata,
  input  logic               w1c,
  input  logic [REG_W-1:0]   w1c_data,
  output logic [REG_W-1:0]   status,
  output logic [REG_W-1:0]   enable,
  output logic               irq
);

  logic [NUM_SRC-1:0] sts_q, sts_d;
  logic [NUM_SRC-1:0] en_q, en_d;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    localparam int unsigned POS = src_pos(gi);
    logic clr;
    assign clr = w1c && w1c_data[POS];
    always_comb begin
      // a clear wins in its own cycle; a lasting condition re-sets next cycle
      sts_d[gi] = clr ? 1'b0 : (sts_q[gi] | src_set[gi]);
      en_d[gi]  = en_we ? en_wdata[POS] : en_q[gi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    status = '0;
    enable = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      status[src_pos(i)] = sts_q[i];
      enable[src_pos(i)] = en_q[i];
    end
  end

  assign irq = |(sts_q & en_q);

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  input  logic              ien_we,
  input  logic [31:0]       ien_wdata,
  input  logic              sts_w1c,
  input  logic [31:0]       sts_wdata,
  input  logic              tx_push,
  input  logic [7:0]        tx_push_data,
  input  logic              tx_pop,
  output logic [7:0]        tx_pop_data,
  output logic              tx_empty,
  input  logic              rx_push,
  input  logic [7:0]        rx_push_data,
  input  logic              rx_pop,
  output logic [7:0]        rx_pop_data,
  output logic              rx_empty,
  input  logic              xfer_done,
  output logic [31:0]       ctl_rdata,
  output logic [31:0]       ien_rdata,
  output logic [31:0]       sts_rdata,
  output logic [31:0]       occ_rdata,
  output logic              irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);

  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             rst_sync_n;
  fifo_cfg_t        cfg;
  logic             rx_flush, tx_flush;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_full, tx_full, rx_ovf, tx_ovf_unused;
  logic             rx_rdy, tx_erq;
  logic [NUM_SRC-1:0] src_set;

  spi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_fifo_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .cfg      (cfg),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .rdata    (ctl_rdata)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(BYTE_W)) u_txf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (tx_flush),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop       (tx_pop),
    .pop_data  (tx_pop_data),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty),
    .overflow  (tx_ovf_unused)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(BYTE_W)) u_rxf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (rx_flush),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .pop_data  (rx_pop_data),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty),
    .overflow  (rx_ovf)
  );

  // level comparisons in the width of the trigger fields
  assign rx_rdy = (LVL_W'(rx_cnt) >= cfg.rx_lvl);
  assign tx_erq = (LVL_W'(tx_cnt) <= cfg.tx_lvl);

  assign rx_dma_req = cfg.rx_dma_en && rx_rdy;
  assign tx_dma_req = cfg.tx_dma_en && tx_erq;

  always_comb begin
    src_set             = '0;
    src_set[SRC_RX_RDY] = rx_rdy;
    src_set[SRC_TX_ERQ] = tx_erq;
    src_set[SRC_RX_OVF] = rx_ovf;
    src_set[SRC_DONE]   = xfer_done;
  end

  spi_irq_status u_sts (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src_set  (src_set),
    .en_we    (ien_we),
    .en_wdata (ien_wdata),
    .w1c      (sts_w1c),
    .w1c_data (sts_wdata),
    .status   (sts_rdata),
    .enable   (ien_rdata),
    .irq      (irq)
  );

  always_comb begin
    occ_rdata = '0;
    occ_rdata[OCC_RX_LSB +: LVL_W] = LVL_W'(rx_cnt);
    occ_rdata[OCC_TX_LSB +: LVL_W] = LVL_W'(tx_cnt);
  end

endmodule

// File: rtl/spi_fifo_irq_ctrl_chk.sv
module spi_fifo_irq_ctrl_chk #(
  parameter int unsigned FIFO_DEPTH = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [31:0] ctl_wdata,
  input logic        sts_w1c,
  input logic [31:0] sts_wdata,
  input logic        rx_push,
  input logic        rx_pop,
  input logic        xfer_done,
  input logic [31:0] ctl_rdata,
  input logic [31:0] ien_rdata,
  input logic [31:0] sts_rdata,
  input logic [31:0] occ_rdata,
  input logic        irq,
  input logic        rx_dma_req
);

  localparam logic [7:0] DEPTH_B = 8'(FIFO_DEPTH);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_rdata == 32'h0) |-> !irq); // R9

  AST_RX_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_rdata[7:0] <= DEPTH_B); // R3

  AST_TX_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_rdata[23:16] <= DEPTH_B); // R11

  AST_FLUSH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[15] && ctl_wdata[31]) |=> (occ_rdata == 32'h0)); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(sts_w1c && sts_wdata[12])) |=> sts_rdata[12]); // R7

  AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w1c && sts_wdata[8]) |=> !sts_rdata[8]); // R8

  AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> ctl_rdata[8]); // R10

  AST_OVF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_rdata[7:0] == DEPTH_B && rx_push && !rx_pop && !(ctl_we && ctl_wdata[15])
     && !(sts_w1c && sts_wdata[8]))
    |=> (occ_rdata[7:0] == DEPTH_B && sts_rdata[8])); // R6

endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .sts_w1c    (sts_w1c),
  .sts_wdata  (sts_wdata),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .xfer_done  (xfer_done),
  .ctl_rdata  (ctl_rdata),
  .ien_rdata  (ien_rdata),
  .sts_rdata  (sts_rdata),
  .occ_rdata  (occ_rdata),
  .irq        (irq),
  .rx_dma_req (rx_dma_req)
);

// File: tb/spi_fifo_irq_ctrl_tb.sv
module spi_fifo_irq_ctrl_tb;

  localparam int unsigned DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        ien_we = 1'b0;
  logic [31:0] ien_wdata = '0;
  logic        sts_w1c = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_push_data = '0;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_pop_data;
  logic        tx_empty;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_push_data = '0;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_pop_data;
  logic        rx_empty;
  logic        xfer_done = 1'b0;
  logic [31:0] ctl_rdata, ien_rdata, sts_rdata, occ_rdata;
  logic        irq, rx_dma_req, tx_dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_irq_ctrl #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .sts_w1c(sts_w1c), .sts_wdata(sts_wdata),
    .tx_push(tx_push), .tx_push_data(tx_push_data),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_empty(rx_empty),
    .xfer_done(xfer_done),
    .ctl_rdata(ctl_rdata), .ien_rdata(ien_rdata),
    .sts_rdata(sts_rdata), .occ_rdata(occ_rdata),
    .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  function automatic logic [31:0] f_occ(input int rxc, input int txc);
    return {8'h00, 8'(txc), 8'h00, 8'(rxc)};
  endfunction

  function automatic logic [31:0] f_ctl(input int rl, input bit rd, input int tl, input bit td);
    return {7'h0, td, 8'(tl), 7'h0, rd, 8'(rl)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [31:0] d);
    ctl_we = 1'b1; ctl_wdata = d; tick(); ctl_we = 1'b0;
  endtask

  task automatic wr_ien(input logic [31:0] d);
    ien_we = 1'b1; ien_wdata = d; tick(); ien_we = 1'b0;
  endtask

  task automatic clr_sts(input logic [31:0] d);
    sts_w1c = 1'b1; sts_wdata = d; tick(); sts_w1c = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_push = 1'b1; tx_push_data = b; tick(); tx_push = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_push = 1'b1; rx_push_data = b; tick(); rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    b = tx_pop_data; tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    b = rx_pop_data; rx_pop = 1'b1; tick(); rx_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    int rl, tl;
    void'($urandom(32'd20240611));

    // R12 reset state
    repeat (3) tick();
    check("R12 ctl", ctl_rdata, 32'h0);
    check("R12 ien", ien_rdata, 32'h0);
    check("R12 sts", sts_rdata, 32'h0);
    check("R12 occ", occ_rdata, 32'h0);
    check("R12 outs", {29'h0, irq, rx_dma_req, tx_dma_req}, 32'h0);
    rst_n = 1'b1;
    repeat (6) tick();

    // levels 0: both level conditions hold after reset
    check("R4 R5 idle status", sts_rdata, 32'h11);
    clr_sts(32'hFFFF_FFFF);
    check("R8 all ones clears", sts_rdata, 32'h0);
    tick();
    check("R8 level re-set", sts_rdata, 32'h11);

    // R1 control write with flush bits
    wr_ctl(32'h8102_8104);
    check("R1 ctl readback", ctl_rdata, 32'h0102_0104);

    // transmit side
    push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
    check("R3 occ tx", occ_rdata, f_occ(0, 3));
    clr_sts(32'h11); tick();
    check("R5 above level", sts_rdata, 32'h0);
    check("R10 dma low", {30'h0, rx_dma_req, tx_dma_req}, 32'h0);
    pop_tx(b);
    check("R3 tx order", {24'h0, b}, 32'hA1);
    clr_sts(32'h11); tick();
    check("R5 at level", sts_rdata, 32'h10);
    check("R10 tx dma", {31'h0, tx_dma_req}, 32'h1);

    // receive side
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    tick();
    check("R4 below level", {31'h0, sts_rdata[0]}, 32'h0);
    push_rx(8'h44); tick();
    check("R4 at level", sts_rdata, 32'h11);
    check("R10 rx dma", {31'h0, rx_dma_req}, 32'h1);
    wr_ien(32'hFFFF_FFFF);
    check("R9 enable map", ien_rdata, 32'h0000_1111);
    check("R9 irq on", {31'h0, irq}, 32'h1);
    wr_ien(32'h0000_1000);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    check("R10 dma ignores ien", {30'h0, rx_dma_req, tx_dma_req}, 32'h3);

    // R7 transfer complete
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    check("R7 done set", {31'h0, sts_rdata[12]}, 32'h1);
    check("R9 irq done", {31'h0, irq}, 32'h1);
    repeat (3) tick();
    check("R7 done sticky", {31'h0, sts_rdata[12]}, 32'h1);
    clr_sts(32'h0000_0001);
    check("R8 zero bits kept", {31'h0, sts_rdata[12]}, 32'h1);
    clr_sts(32'h0000_1000); tick();
    check("R8 done cleared", {31'h0, sts_rdata[12]}, 32'h0);
    check("R9 irq off", {31'h0, irq}, 32'h0);

    // R2 flush both in one write
    wr_ctl(32'h8102_8104);
    check("R2 flushed", occ_rdata, 32'h0);
    check("R1 ctl kept", ctl_rdata, 32'h0102_0104);

    // R6 overflow
    wr_ctl(32'h0);
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i * 3 + 1));
    push_rx(8'hEE); tick();
    check("R6 count held", occ_rdata, f_occ(DEPTH, 0));
    check("R6 ovf bit", {31'h0, sts_rdata[8]}, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_rx(b);
      check("R6 data intact", {24'h0, b}, 32'(8'(i * 3 + 1)));
    end
    rx_pop = 1'b1; tick(); rx_pop = 1'b0;
    check("R11 pop empty", occ_rdata, 32'h0);
    clr_sts(32'h100); tick();
    check("R8 event stays clear", {31'h0, sts_rdata[8]}, 32'h0);

    // R11 transmit full
    for (int i = 0; i <= DEPTH; i++) push_tx(8'(i));
    check("R11 tx full", occ_rdata, f_occ(0, DEPTH));
    wr_ctl(32'h8000_0000);
    check("R2 tx flush", occ_rdata, 32'h0);

    // random phase: R3 R4 R5 R10
    rl = 0; tl = 0;
    for (int it = 0; it < 400; it++) begin
      bit rpu, rpo, tpu, tpo, rok, tok;
      logic [7:0] rb, tb;
      if (it % 40 == 0) begin
        rl = $urandom_range(0, DEPTH);
        tl = $urandom_range(0, DEPTH);
        wr_ctl(f_ctl(rl, 1'b1, tl, 1'b1));
        check("R1 random ctl", ctl_rdata, f_ctl(rl, 1'b1, tl, 1'b1));
      end
      rpu = ($urandom_range(0, 99) < 55);
      rpo = ($urandom_range(0, 99) < 45);
      tpu = ($urandom_range(0, 99) < 55);
      tpo = ($urandom_range(0, 99) < 45);
      rb = 8'($urandom); tb = 8'($urandom);
      if (rpo && rxq.size() > 0) check("R3 rx head", {24'h0, rx_pop_data}, {24'h0, rxq[0]});
      if (tpo && txq.size() > 0) check("R3 tx head", {24'h0, tx_pop_data}, {24'h0, txq[0]});
      rx_push = rpu; rx_push_data = rb; rx_pop = rpo;
      tx_push = tpu; tx_push_data = tb; tx_pop = tpo;
      tick();
      rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
      rok = rpo && rxq.size() > 0;
      tok = tpo && txq.size() > 0;
      if (rpu && (rxq.size() < DEPTH || rok)) begin
        if (rok) void'(rxq.pop_front());
        rxq.push_back(rb);
      end else if (rok) void'(rxq.pop_front());
      if (tpu && (txq.size() < DEPTH || tok)) begin
        if (tok) void'(txq.pop_front());
        txq.push_back(tb);
      end else if (tok) void'(txq.pop_front());
      clr_sts(32'h11); tick();
      check("R3 random occ", occ_rdata, f_occ(rxq.size(), txq.size()));
      check("R4 random rdy", {31'h0, sts_rdata[0]}, {31'h0, rxq.size() >= rl});
      check("R5 random erq", {31'h0, sts_rdata[4]}, {31'h0, txq.size() <= tl});
      check("R10 random dma", {30'h0, rx_dma_req, tx_dma_req},
            {30'h0, rxq.size() >= rl, txq.size() <= tl});
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule